// File: doc/BRIEF.md
# Three-Wire Serial Control Frame Receiver

This block takes control frames from a host over three wires: a serial clock, a data line and an enable line. While enable is low the host clocks in an 8-bit device address. While enable is high it clocks in a 44-bit data word. When enable falls, the block checks whether the address named this device. If it did and the word is complete, the block presents the word together with a one-cycle valid strobe.

All three pins are oversampled by a fast system clock. Each pin passes through a two-flop synchronizer, and edges are found in the system clock domain. The data path keeps only the most recent 44 data bits. A host that can only send whole bytes may therefore put four padding bits ahead of the real word and send 48 bits. The block only delivers the raw word; it does not interpret any field of it.

Top module: `serial_ctrl_rx`

## Requirements
- R1: Address bits are taken on rising edges of `sclk_i` while `sen_i` is low, first bit into bit 0. A frame is accepted only if the last 8 such bits equal hexadecimal 81: the first and the eighth address bits are 1 and the others are 0.
- R2: Data bits are taken on rising edges of `sclk_i` while `sen_i` is high. When exactly 44 bits are sent, the first bit sent appears on `word_o[0]` and the last on `word_o[43]`.
- R3: When more than 44 data bits are sent, only the final 44 are kept. Bit `word_o[i]` is data bit number n-44+i, counted from 0, where n is the number of bits sent. This lets a host send 4 padding bits ahead of a 44-bit word.
- R4: When `sen_i` falls after a matching address and at least 44 data bits, `valid_o` is high for exactly one `clk_i` cycle. `word_o` takes the new word in that same cycle and holds it until the next strobe.
- R5: When the address does not match, the fall of `sen_i` raises neither `valid_o` nor `err_o`, and `word_o` is unchanged.
- R6: When the address matches but fewer than 44 data bits were sent, `err_o` is high for one cycle, `valid_o` stays low and `word_o` is unchanged.
- R7: While `rst_ni` is low, `word_o` is 0 and `valid_o` and `err_o` are low.
- R8: The address register is cleared when `sen_i` rises. A frame whose enable-low phase carried no address bits is rejected like a mismatch, even if the previous frame matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Serial data from the host |
| sen_i | input | 1 | Enable line: low for the address phase, high for the data phase |
| word_o | output | 44 | Most recently accepted data word |
| valid_o | output | 1 | One-cycle strobe marking a newly accepted word |
| err_o | output | 1 | One-cycle pulse for an addressed frame that was too short |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 44-bit word, device code 81 hex and two synchronizer stages. The serial clock runs at four system clocks per period. With an address this narrow, all 256 address values can be swept, so the single matching code and every mismatch are each seen in a full frame. At the matching address, the data length is swept from 0 to 48 bits. This reaches every short frame that must raise an error, the exact 44-bit frame, and every padded frame up to the 48-bit byte-multiple case. A frame with no address bits, sent right after a good frame, shows that the address register is cleared.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic sen_lvl;
    logic sen_rise;
    logic sen_fall;
    logic sclk_rise;
    logic sdata;
  } pin_ev_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serial_rx_addr.sv
module serial_rx_addr #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_CODE = 8'h81
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  serial_rx_pkg::pin_ev_t ev_i,
  output logic                   hit_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              shift_en;

  assign shift_en = ev_i.sclk_rise && !ev_i.sen_lvl;

  // first bit lands in bit 0 after ADDR_W shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      hit_o  <= 1'b0;
    end else if (ev_i.sen_rise) begin
      hit_o  <= (addr_q == DEV_CODE);
      addr_q <= '0;
    end else if (shift_en) begin
      addr_q <= {ev_i.sdata, addr_q[ADDR_W-1:1]};
    end
  end

  a_r8_addr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.sen_rise |=> (addr_q == '0));
endmodule

// File: rtl/serial_rx_data.sv
module serial_rx_data #(
  parameter int DATA_W = 44
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  serial_rx_pkg::pin_ev_t ev_i,
  output logic [DATA_W-1:0]      data_o,
  output logic                   full_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              shift_en;

  assign shift_en = ev_i.sclk_rise && ev_i.sen_lvl;

  // right shift keeps the newest DATA_W bits; older padding falls out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (ev_i.sen_rise) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q <= {ev_i.sdata, sh_q[DATA_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = sh_q;
  assign full_o = (cnt_q == CNT_MAX);

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  a_r6_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.sen_rise |=> (cnt_q == '0));
endmodule

// File: rtl/serial_ctrl_rx.sv
module serial_ctrl_rx #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 44,
  parameter logic [ADDR_W-1:0] DEV_CODE    = 8'h81,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  import serial_rx_pkg::*;

  logic [2:0]        pins_s;
  logic              sclk_p, sen_p;
  pin_ev_t           ev;
  logic              hit;
  logic              full;
  logic [DATA_W-1:0] data;

  serial_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sen_i, sdata_i, sclk_i}),
    .q_o    (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= 1'b0;
      sen_p  <= 1'b0;
    end else begin
      sclk_p <= pins_s[0];
      sen_p  <= pins_s[2];
    end
  end

  assign ev.sen_lvl   = pins_s[2];
  assign ev.sen_rise  = pins_s[2] && !sen_p;
  assign ev.sen_fall  = !pins_s[2] && sen_p;
  assign ev.sclk_rise = pins_s[0] && !sclk_p;
  assign ev.sdata     = pins_s[1];

  serial_rx_addr #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .hit_o  (hit)
  );

  serial_rx_data #(.DATA_W(DATA_W)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .data_o (data),
    .full_o (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (ev.sen_fall && hit) begin
        if (full) begin
          word_o  <= data;
          valid_o <= 1'b1;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r4_valid_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(ev.sen_fall));
  a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r6_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && valid_o));
  a_r5_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
endmodule

// File: tb/serial_ctrl_rx_bench.sv
`timescale 1ns/1ps
module serial_ctrl_rx_bench;
  localparam int DW = 44;
  localparam int H  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [DW-1:0] word;
  logic          valid, err;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_err = 0;
  logic [DW-1:0] exp_word = '0;

  always #2 clk = ~clk;

  serial_ctrl_rx u_serial_ctrl_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .word_o(word), .valid_o(valid), .err_o(err)
  );

  always @(negedge clk) begin
    if (valid) n_valid++;
    if (err)   n_err++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bit_out(input logic b);
    sdata = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [7:0] a, input int na, input int nd,
                       input logic [47:0] pat);
    for (int i = 0; i < na; i++) bit_out(a[i]);
    repeat (H) @(negedge clk);
    sen = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nd; i++) bit_out(pat[i]);
    repeat (H) @(negedge clk);
    sen = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [47:0] mkpat(input int k);
    logic [47:0] p;
    p = 48'h5A3C_96F0_1E2D ^ (48'(k) * 48'h0101_0303_0707);
    return p ^ {p[23:0], p[47:24]};
  endfunction

  task automatic run_frame(input logic [7:0] a, input int na, input int nd,
                           input logic [47:0] pat, input string req);
    int v0, e0;
    bit hit, full;
    v0 = n_valid; e0 = n_err;
    frame(a, na, nd, pat);
    hit  = (na == 8) && (a == 8'h81);
    full = (nd >= DW);
    if (hit && full) exp_word = DW'(pat >> (nd - DW));
    chk(n_valid - v0 == ((hit && full) ? 1 : 0), {req, " valid"}, 64'(n_valid - v0),
        64'((hit && full) ? 1 : 0));
    chk(n_err - e0 == ((hit && !full) ? 1 : 0), {req, " err"}, 64'(n_err - e0),
        64'((hit && !full) ? 1 : 0));
    chk(word === exp_word, {req, " word"}, 64'(word), 64'(exp_word));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(word === '0, "R7 word", 64'(word), 0);
    chk(!valid && !err, "R7 strobes", {62'b0, valid, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_frame(8'h81, 8, 44, 48'h0000_0000_0001, "R2 first bit to bit0");
    run_frame(8'h81, 8, 44, 48'h0800_0000_0000, "R2 last bit to bit43");
    for (int a = 0; a < 256; a++)
      run_frame(8'(a), 8, 44, mkpat(a), (a == 8'h81) ? "R1 R4 match" : "R1 R5 mismatch");
    for (int n = 0; n <= 48; n++)
      run_frame(8'h81, 8, n, mkpat(n + 7), (n < DW) ? "R6 short" : "R3 R4 length");
    run_frame(8'h81, 8, 44, mkpat(999), "R4 good before R8");
    run_frame(8'h00, 0, 44, mkpat(500), "R8 no address bits");
    run_frame(8'h81, 8, 48, 48'hFFF0_0000_0000 | 48'hF, "R3 padding 48");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule